// File: doc/BRIEF.md
# Retirement Load Value Checker

This block sits at the retirement point of an out-of-order core and decides whether a retiring load may commit. A load that ran ahead of earlier stores may have picked up a stale value. Once such a load reaches retirement, every older store has already written memory. The checker therefore reads the same address a second time and compares the new value with the value the load obtained when it first executed. If the two values are equal, the load commits. If they differ, the checker asks the pipeline to flush and restart from that load.

A load that ran in program order needs no second read, and the checker returns a commit result for it on the next cycle. While a check is under way, the `busy` output holds retirement back. Only one memory read is ever outstanding.

Violations are found by comparing values, not by searching a queue of load addresses. A store to the same address that wrote an unchanged value therefore causes no flush.

Top module: `retire_load_checker`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `res_valid` and `mem_req_valid` are all 0 until a retire request is accepted.
- R2: A retire request is accepted when `ret_valid`=1 and `busy`=0. If it is accepted with `ret_ooo`=0, no memory request is made, and in the next cycle `res_valid`=1 with `res_flush`=0.
- R3: A request accepted with `ret_ooo`=1 raises `mem_req_valid` in the next cycle, with `mem_req_addr` equal to the accepted `ret_addr`. Both stay unchanged until a cycle in which `mem_req_ready`=1.
- R4: If the response data (`mem_rsp_data`) equals the accepted `ret_data`, the result is a commit: `res_valid`=1 and `res_flush`=0, in the cycle after the response.
- R5: If the response data differs from `ret_data` in any bit position, the result is a flush: `res_valid`=1 and `res_flush`=1, in the cycle after the response.
- R6: `busy` is 1 from the cycle after acceptance through the result cycle. A `ret_valid` that arrives while `busy`=1 is ignored and leaves the pending result unchanged.
- R7: `res_valid` is high for exactly one cycle per accepted request. In the following cycle `busy` returns to 0.
- R8: A `mem_rsp_valid` that arrives before the memory request has been accepted is ignored.
- R9: After a memory request has been accepted, `mem_req_valid` stays 0 until the response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | A retiring load is presented |
| ret_ooo | input | 1 | The load executed ahead of program order |
| ret_addr | input | ADDR_W | Load address |
| ret_data | input | DATA_W | Value the load obtained when it first executed |
| busy | output | 1 | Check in progress; hold retirement |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DATA_W | Read data |
| res_valid | output | 1 | One-cycle result pulse |
| res_flush | output | 1 | 1 = flush and restart at this load, 0 = commit |

## Verification
The bench flips each of the 32 data bits one at a time, so a comparator that ignores any lane or any bit would commit a load it should flush. It also runs equal values under every combination of ready delay and response delay, so a checker that flushes on timing alone would show up. Stray responses are injected while the request is still unaccepted, and new retire requests are injected while a check is busy. A design that latched either of these would take a wrong value or report a premature commit. In-order loads are checked for issuing no memory read and for returning a result after exactly one cycle.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_REQUEST  = 2'd1,
    ST_WAIT_RSP = 2'd2,
    ST_RESULT   = 2'd3
  } rlc_state_e;
endpackage

// File: rtl/rlc_hold.sv
module rlc_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load_en) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end
endmodule

// File: rtl/rlc_cmp.sv
module rlc_cmp #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] orig,
  input  logic [DATA_W-1:0] fresh,
  output logic              differ
);
  localparam int LANES = (DATA_W + LANE_W - 1) / LANE_W;
  localparam int PAD_W = LANES * LANE_W;

  logic [PAD_W-1:0] orig_p;
  logic [PAD_W-1:0] fresh_p;
  logic [LANES-1:0] lane_diff;

  always_comb begin
    orig_p  = '0;
    fresh_p = '0;
    orig_p[DATA_W-1:0]  = orig;
    fresh_p[DATA_W-1:0] = fresh;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_diff[g] = |(orig_p[g*LANE_W +: LANE_W] ^ fresh_p[g*LANE_W +: LANE_W]);
  end

  assign differ = |lane_diff;
endmodule

// File: rtl/rlc_ctrl.sv
module rlc_ctrl
  import rlc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ret_valid,
  input  logic ret_ooo,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic differ,
  output logic capture_en,
  output logic busy,
  output logic mem_req_valid,
  output logic res_valid,
  output logic res_flush
);
  rlc_state_e state_q, state_d;
  logic       flush_q, flush_d;
  logic       flush_en;

  always_comb begin
    state_d    = state_q;
    flush_d    = flush_q;
    flush_en   = 1'b0;
    capture_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ret_valid) begin
          capture_en = 1'b1;
          if (ret_ooo) begin
            state_d = ST_REQUEST;
          end else begin
            state_d  = ST_RESULT;
            flush_d  = 1'b0;
            flush_en = 1'b1;
          end
        end
      end
      ST_REQUEST: begin
        if (mem_req_ready) state_d = ST_WAIT_RSP;
      end
      ST_WAIT_RSP: begin
        if (mem_rsp_valid) begin
          state_d  = ST_RESULT;
          flush_d  = differ;
          flush_en = 1'b1;
        end
      end
      ST_RESULT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      flush_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (flush_en) flush_q <= flush_d;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQUEST);
  assign res_valid     = (state_q == ST_RESULT);
  assign res_flush     = res_valid & flush_q;
endmodule

// File: rtl/retire_load_checker.sv
module retire_load_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic              ret_ooo,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [DATA_W-1:0] ret_data,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              res_valid,
  output logic              res_flush
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              capture_en;
  logic              differ;
  logic [DATA_W-1:0] orig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rlc_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (capture_en),
    .addr_in (ret_addr),
    .data_in (ret_data),
    .addr_q  (mem_req_addr),
    .data_q  (orig_q)
  );

  rlc_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
    .orig   (orig_q),
    .fresh  (mem_rsp_data),
    .differ (differ)
  );

  rlc_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .ret_valid     (ret_valid),
    .ret_ooo       (ret_ooo),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .differ        (differ),
    .capture_en    (capture_en),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .res_valid     (res_valid),
    .res_flush     (res_flush)
  );
endmodule

// File: rtl/rlc_checker.sv
module rlc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ret_valid,
  input logic              ret_ooo,
  input logic [ADDR_W-1:0] ret_addr,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              res_valid,
  input logic              res_flush
);
  logic outstanding_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              outstanding_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outstanding_q <= 1'b1;
    else if (mem_rsp_valid)                  outstanding_q <= 1'b0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !res_valid));

  assert_inorder_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !busy && !ret_ooo) |=> (res_valid && !res_flush && !mem_req_valid));

  assert_issue_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !busy && ret_ooo) |=> (mem_req_valid && mem_req_addr == $past(ret_addr)));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_busy_cover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);

  assert_one_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!res_valid && !busy));

  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding_q |-> !mem_req_valid);
endmodule

bind retire_load_checker rlc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rlc_checker (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .ret_valid     (ret_valid),
  .ret_ooo       (ret_ooo),
  .ret_addr      (ret_addr),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .res_valid     (res_valid),
  .res_flush     (res_flush)
);

// File: tb/retire_load_checker_bench.sv
module retire_load_checker_bench;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ret_valid, ret_ooo;
  logic [AW-1:0] ret_addr;
  logic [DW-1:0] ret_data;
  logic          busy, mem_req_valid, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;
  logic          res_valid, res_flush;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  retire_load_checker u_retire_load_checker (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_ooo(ret_ooo),
    .ret_addr(ret_addr), .ret_data(ret_data), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_flush(res_flush)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_inorder(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ret_valid = 1'b1; ret_ooo = 1'b0; ret_addr = a; ret_data = d;
    @(negedge clk);
    ret_valid = 1'b0;
    check(res_valid == 1'b1, "R2 result valid", res_valid, 1);
    check(res_flush == 1'b0, "R2 commit", res_flush, 0);
    check(mem_req_valid == 1'b0, "R2 no mem read", mem_req_valid, 0);
    check(busy == 1'b1, "R6 busy in result", busy, 1);
    @(negedge clk);
    check(res_valid == 1'b0 && busy == 1'b0, "R7 pulse ends", {res_valid, busy}, 0);
  endtask

  task automatic run_ooo(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [DW-1:0] memval, input int rdy_dly, input int rsp_dly);
    logic exp_flush;
    exp_flush = (d != memval);
    @(negedge clk);
    ret_valid = 1'b1; ret_ooo = 1'b1; ret_addr = a; ret_data = d;
    @(negedge clk);
    ret_valid = 1'b0;
    ret_addr  = ~a;
    check(mem_req_valid == 1'b1, "R3 request raised", mem_req_valid, 1);
    check(mem_req_addr == a, "R3 request address", mem_req_addr, a);
    for (int i = 0; i < rdy_dly; i++) begin
      mem_rsp_valid = 1'b1; mem_rsp_data = ~memval;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      check(mem_req_valid == 1'b1 && mem_req_addr == a, "R8 stray response ignored / R3 hold",
            mem_req_addr, a);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check(mem_req_valid == 1'b0, "R9 no second request", mem_req_valid, 0);
    for (int i = 0; i < rsp_dly; i++) begin
      ret_valid = 1'b1; ret_ooo = 1'b0; ret_data = ~d;
      @(negedge clk);
      ret_valid = 1'b0;
      check(res_valid == 1'b0 && busy == 1'b1 && mem_req_valid == 1'b0,
            "R6 waiting, new request ignored", {res_valid, busy, mem_req_valid}, 3'b010);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = memval;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check(res_valid == 1'b1, "R4/R5 result valid", res_valid, 1);
    if (exp_flush) check(res_flush == 1'b1, "R5 flush on mismatch", res_flush, 1);
    else           check(res_flush == 1'b0, "R4 commit on match", res_flush, 0);
    @(negedge clk);
    check(res_valid == 1'b0 && busy == 1'b0, "R7 single pulse", {res_valid, busy}, 0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    ret_valid = 1'b0; ret_ooo = 1'b0; ret_addr = '0; ret_data = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && res_valid == 1'b0 && mem_req_valid == 1'b0, "R1 in reset",
          {busy, res_valid, mem_req_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && res_valid == 1'b0 && mem_req_valid == 1'b0, "R1 after reset",
          {busy, res_valid, mem_req_valid}, 0);

    run_inorder(32'h0000_1000, 32'hDEAD_BEEF);
    run_inorder(32'hFFFF_FFFC, 32'h0);

    for (int r = 0; r < 4; r++)
      for (int s = 0; s < 4; s++)
        run_ooo(32'h2000_0000 + 32'(r * 16 + s * 4), 32'hA5A5_0000 + 32'(r * 4 + s),
                32'hA5A5_0000 + 32'(r * 4 + s), r, s);

    for (int b = 0; b < DW; b++) begin
      logic [DW-1:0] orig;
      orig = 32'h1357_9BDF ^ 32'(b * 32'h0101_0101);
      run_ooo(32'h3000_0000 + 32'(b * 4), orig, orig ^ (32'h1 << b), b % 3, b % 4);
    end

    run_inorder(32'h4000_0000, 32'h1);
    run_ooo(32'h5000_0000, 32'h0, 32'h0, 0, 0);
    run_ooo(32'h5000_0004, 32'hFFFF_FFFF, 32'h0, 1, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule